// File: doc/BRIEF.md
# Event Interrupt Controller

This block gathers four radio-status events into one interrupt line. The events are a counter-done pulse, a rising edge on the AFC out-of-range flag, a change in the 7-bit field-strength value, and a change in the stereo flag. A mask byte enables each event on its own. An enabled event sets a pending bit in an identify byte. The field-strength and stereo changes share one pending bit. The interrupt output is asserted while any enabled pending bit is set. It is also asserted while software holds a force bit. A mask bit chooses whether the line is active high or active low.

Software programs the block through a single-cycle write port and reads it through a combinational read port. Reading the identify byte returns the pending bits and clears them in the same access. The field-strength, stereo and AFC inputs are sampled every cycle. Each change is detected against the previous sample, and the sampled values can be read back.

Top module: `evtirq_top`

## Requirements
- R1: When mask bit 0 (register address 0) is 1, a high `cntDone` at a clock edge sets identify bit 5. When mask bit 0 is 0, `cntDone` sets nothing.
- R2: When mask bit 2 is 1, `afcIn` going from 0 to 1 between two consecutive samples sets identify bit 3. A level that stays high does not set it again.
- R3: When mask bit 1 is 1, `fsIn` differing from its value at the previous clock edge sets identify bit 0. The first edge after reset has no previous sample and reports no change.
- R4: When mask bit 6 is 1, `stereoIn` differing from its previous sample sets identify bit 0, the same bit used for field-strength changes.
- R5: The identify byte (read address 2) always returns ones in bits 7 and 6 and zeros in bits 4, 2 and 1.
- R6: A read of address 2 clears every pending bit in the following cycle. An event latched at the edge of that read stays pending.
- R7: The interrupt is active while any pending bit is set whose enable is 1. The enable for bit 5 is mask bit 0, for bit 3 mask bit 2, and for bit 0 mask bit 1 OR mask bit 6. Mask bit 3 = 1 makes the output active low; 0 makes it active high.
- R8: Writing 1 to bit 0 of address 1 makes the interrupt active regardless of pending state, until a write of 0 there.
- R9: Address 3 reads {sampled stereo, sampled field strength} with stereo in bit 7. Address 4 reads the sampled AFC flag in bit 0 with zeros above it. Any other address, and any cycle with `rdEn` low, reads 0.
- R10: After reset the mask, force and pending state are zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data, combinational |
| cntDone | input | 1 | Counter-done event pulse |
| afcIn | input | 1 | AFC out-of-range flag |
| fsIn | input | 7 | Field-strength value |
| stereoIn | input | 1 | Stereo flag |
| irqOut | output | 1 | Interrupt output, programmable polarity |

## Verification
Directed phases first apply each event source alone. Each source is applied with its mask bit clear and then set, which separates a missing gate from a missing latch. A held AFC level separates edge detection from level detection. A field-strength step made while only the stereo enable is on shows that the two change sources are masked independently even though they share one pending bit. One phase applies a counter pulse in the same cycle as an identify read, which separates clear-then-set ordering from set-then-clear ordering. A final stretch of random writes, reads and input changes, with the polarity bit flipping, is compared each cycle against a behavioural model.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int FS_W     = 7;
  localparam int NUM_SLOT = 3;

  localparam logic [ADDR_W-1:0] A_MASK    = 3'd0;
  localparam logic [ADDR_W-1:0] A_FORCE   = 3'd1;
  localparam logic [ADDR_W-1:0] A_IDENT   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATION = 3'd3;
  localparam logic [ADDR_W-1:0] A_AFCSTAT = 3'd4;

  // mask byte bit positions
  localparam int MB_CNT = 0;
  localparam int MB_FS  = 1;
  localparam int MB_AFC = 2;
  localparam int MB_POL = 3;
  localparam int MB_ST  = 6;

  // pending slot indices and their identify-byte positions
  localparam int S_FSMS = 0;
  localparam int S_AFC  = 1;
  localparam int S_CNT  = 2;
  localparam int SLOT_POS [NUM_SLOT] = '{0, 3, 5};
  localparam logic [DATA_W-1:0] ID_FIXED_ONES = 8'hC0;

  typedef enum logic [1:0] {RD_NONE, RD_IDENT, RD_STATION, RD_AFC} rdSel_t;

  typedef struct packed {
    logic              maskWr;
    logic              forceWr;
    rdSel_t            rdSel;
    logic [DATA_W-1:0] wrByte;
  } ctlStrobe_t;
endpackage

// File: rtl/evtirq_ctrl.sv
module evtirq_ctrl
  import evtirq_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctlStrobe_t        strobe
);
  always_comb begin
    strobe         = '0;
    strobe.wrByte  = wrData;
    strobe.maskWr  = wrEn && (wrAddr == A_MASK);
    strobe.forceWr = wrEn && (wrAddr == A_FORCE);
    strobe.rdSel   = RD_NONE;
    if (rdEn) begin
      unique case (rdAddr)
        A_IDENT:   strobe.rdSel = RD_IDENT;
        A_STATION: strobe.rdSel = RD_STATION;
        A_AFCSTAT: strobe.rdSel = RD_AFC;
        default:   strobe.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/evtirq_dp.sv
module evtirq_dp
  import evtirq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic                cntDone,
  input  logic                afcIn,
  input  logic [FS_W-1:0]     fsIn,
  input  logic                stereoIn,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqOut,
  output logic [NUM_SLOT-1:0] pendVec,
  output logic [DATA_W-1:0]   maskQ,
  output logic                forceQ
);
  logic [FS_W-1:0]     fsSmp;
  logic                stSmp;
  logic                afcSmp;
  logic                smpValid;
  logic [NUM_SLOT-1:0] evt;
  logic [NUM_SLOT-1:0] slotEn;
  logic [DATA_W-1:0]   identByte;
  logic                identRd;
  logic                anyActive;
  logic                unusedMaskBits;

  assign unusedMaskBits = ^{maskQ[7], maskQ[5:4]};
  assign identRd = (strobe.rdSel == RD_IDENT);

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      forceQ <= 1'b0;
    end else begin
      if (strobe.maskWr)  maskQ  <= strobe.wrByte;
      if (strobe.forceWr) forceQ <= strobe.wrByte[0];
    end
  end

  // input samples, previous value for change detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsSmp    <= '0;
      stSmp    <= 1'b0;
      afcSmp   <= 1'b0;
      smpValid <= 1'b0;
    end else begin
      fsSmp    <= fsIn;
      stSmp    <= stereoIn;
      afcSmp   <= afcIn;
      smpValid <= 1'b1;
    end
  end

  always_comb begin
    evt[S_CNT]  = cntDone & maskQ[MB_CNT];
    evt[S_AFC]  = smpValid & afcIn & ~afcSmp & maskQ[MB_AFC];
    evt[S_FSMS] = smpValid & (((fsIn != fsSmp) & maskQ[MB_FS]) |
                              ((stereoIn != stSmp) & maskQ[MB_ST]));
    slotEn[S_CNT]  = maskQ[MB_CNT];
    slotEn[S_AFC]  = maskQ[MB_AFC];
    slotEn[S_FSMS] = maskQ[MB_FS] | maskQ[MB_ST];
  end

  // one pending flop per slot: clear on identify read, new event wins
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendVec[s] <= 1'b0;
      else       pendVec[s] <= (pendVec[s] & ~identRd) | evt[s];
    end
  end

  always_comb begin
    identByte = ID_FIXED_ONES;
    for (int s = 0; s < NUM_SLOT; s++) identByte[SLOT_POS[s]] = pendVec[s];
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_IDENT:   rdData = identByte;
      RD_STATION: rdData = {stSmp, fsSmp};
      RD_AFC:     rdData = {{(DATA_W-1){1'b0}}, afcSmp};
      default:    rdData = '0;
    endcase
  end

  assign anyActive = (|(pendVec & slotEn)) | forceQ;
  assign irqOut    = anyActive ^ maskQ[MB_POL];
endmodule

// File: rtl/evtirq_top.sv
module evtirq_top
  import evtirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              cntDone,
  input  logic              afcIn,
  input  logic [FS_W-1:0]   fsIn,
  input  logic              stereoIn,
  output logic              irqOut
);
  ctlStrobe_t          strobe;
  logic [NUM_SLOT-1:0] pendVec;
  logic [DATA_W-1:0]   maskQ;
  logic                forceQ;

  evtirq_ctrl u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .strobe(strobe)
  );

  evtirq_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cntDone(cntDone), .afcIn(afcIn), .fsIn(fsIn), .stereoIn(stereoIn),
    .rdData(rdData), .irqOut(irqOut),
    .pendVec(pendVec), .maskQ(maskQ), .forceQ(forceQ)
  );
endmodule

// File: rtl/evtirq_chk.sv
module evtirq_chk
  import evtirq_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   rdAddr,
  input logic [DATA_W-1:0]   rdData,
  input logic                cntDone,
  input logic                irqOut,
  input logic [NUM_SLOT-1:0] pendVec,
  input logic [DATA_W-1:0]   maskQ,
  input logic                forceQ
);
  p_cnt_latch_r1: assert property (@(posedge clk) disable iff (!rstN)
    cntDone && maskQ[MB_CNT] |=> pendVec[S_CNT]);

  p_cnt_masked_r1: assert property (@(posedge clk) disable iff (!rstN)
    !maskQ[MB_CNT] && !pendVec[S_CNT] |=> !pendVec[S_CNT]);

  p_ident_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && rdAddr == A_IDENT |-> rdData[7:6] == 2'b11 && !rdData[4] && rdData[2:1] == 2'b00);

  p_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && rdAddr == A_IDENT && !cntDone |=> !pendVec[S_CNT]);

  p_idle_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    !forceQ && pendVec == '0 |-> irqOut == maskQ[MB_POL]);

  p_force_r8: assert property (@(posedge clk) disable iff (!rstN)
    forceQ |-> irqOut == !maskQ[MB_POL]);
endmodule

bind evtirq_top evtirq_chk u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
  .cntDone(cntDone), .irqOut(irqOut), .pendVec(pendVec),
  .maskQ(maskQ), .forceQ(forceQ)
);

// File: tb/tb_evtirq_top.sv
module tb_evtirq_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       cntDone = 1'b0;
  logic       afcIn = 1'b0;
  logic [6:0] fsIn = '0;
  logic       stereoIn = 1'b0;
  logic       irqOut;

  int checks = 0;
  int fails = 0;
  bit running = 1'b0;
  string phase = "R10";

  // behavioural reference state
  bit [7:0] mMask = '0;
  bit       mForce = 1'b0;
  bit [7:0] mPend = '0;
  bit [6:0] mFs = '0;
  bit       mSt = 1'b0;
  bit       mAfc = 1'b0;
  bit       mValid = 1'b0;
  bit [7:0] ev;

  evtirq_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .cntDone(cntDone),
    .afcIn(afcIn), .fsIn(fsIn), .stereoIn(stereoIn), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMask = '0; mForce = 1'b0; mPend = '0;
      mFs = '0; mSt = 1'b0; mAfc = 1'b0; mValid = 1'b0;
    end else begin
      ev = '0;
      if (cntDone && mMask[0]) ev[5] = 1'b1;
      if (mValid && afcIn && !mAfc && mMask[2]) ev[3] = 1'b1;
      if (mValid && ((fsIn != mFs && mMask[1]) || (stereoIn != mSt && mMask[6]))) ev[0] = 1'b1;
      if (rdEn && rdAddr == 3'd2) mPend = '0;
      mPend = mPend | ev;
      if (wrEn && wrAddr == 3'd0) mMask = wrData;
      if (wrEn && wrAddr == 3'd1) mForce = wrData[0];
      mFs = fsIn; mSt = stereoIn; mAfc = afcIn; mValid = 1'b1;
    end
  end

  function automatic bit expIrq();
    bit act;
    act = (mPend[5] && mMask[0]) || (mPend[3] && mMask[2]) ||
          (mPend[0] && (mMask[1] || mMask[6])) || mForce;
    return act ^ mMask[3];
  endfunction

  function automatic bit [7:0] expRd();
    if (!rdEn) return 8'h00;
    case (rdAddr)
      3'd2:    return 8'hC0 | mPend;
      3'd3:    return {mSt, mFs};
      3'd4:    return {7'd0, mAfc};
      default: return 8'h00;
    endcase
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    #2;
    if (running) begin
      checks++;
      if (irqOut !== expIrq()) begin
        fails++;
        $display("FAIL %s irqOut got %b exp %b at %0t", phase, irqOut, expIrq(), $time);
      end
      checks++;
      if (rdData !== expRd()) begin
        fails++;
        $display("FAIL %s rdData addr %0d got %h exp %h at %0t", phase, rdAddr, rdData, expRd(), $time);
      end
    end
  end

  task automatic cyc(input bit we, input bit [2:0] wa, input bit [7:0] wd,
                     input bit re, input bit [2:0] ra, input bit cnt);
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd;
    rdEn = re; rdAddr = ra; cntDone = cnt;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic setMask(input bit [7:0] m);
    cyc(1, 3'd0, m, 0, 0, 0);
  endtask

  task automatic readId();
    cyc(0, 0, 0, 1, 3'd2, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog got running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1 rstN = 1'b0;
    running = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    // R10: reset state, identify reads empty
    phase = "R10";
    readId(); readId(); idle(1);

    // R1: masked counter pulse ignored, enabled pulse latched
    phase = "R1";
    cyc(0, 0, 0, 0, 0, 1); idle(1); readId();
    setMask(8'h01);
    cyc(0, 0, 0, 0, 0, 1); idle(2); readId(); idle(1);

    // R2: AFC rising edge only
    phase = "R2";
    setMask(8'h04);
    afcIn = 1'b1; idle(3); readId(); idle(2); readId();
    afcIn = 1'b0; idle(1); readId();

    // R3: field-strength change
    phase = "R3";
    setMask(8'h02);
    fsIn = 7'd5; idle(1); readId(); idle(1);
    fsIn = 7'd9; idle(2); readId(); idle(1);

    // R4: stereo change shares bit 0; fs change masked here
    phase = "R4";
    setMask(8'h40);
    fsIn = 7'd77; idle(1); readId();
    stereoIn = 1'b1; idle(1); readId(); idle(1);

    // R6: event in the same cycle as an identify read stays pending
    phase = "R6";
    setMask(8'h01);
    cyc(0, 0, 0, 1, 3'd2, 1); idle(1); readId(); idle(1);

    // R7: active-low polarity, then mask removed while pending
    phase = "R7";
    setMask(8'h09);
    cyc(0, 0, 0, 0, 0, 1); idle(2);
    setMask(8'h08); idle(1); readId(); idle(1);

    // R8: software force
    phase = "R8";
    setMask(8'h00);
    cyc(1, 3'd1, 8'h01, 0, 0, 0); idle(2);
    cyc(1, 3'd1, 8'h00, 0, 0, 0); idle(1);

    // R9: status reads
    phase = "R9";
    afcIn = 1'b1; fsIn = 7'h2A; stereoIn = 1'b0; idle(1);
    cyc(0, 0, 0, 1, 3'd3, 0); cyc(0, 0, 0, 1, 3'd4, 0);
    cyc(0, 0, 0, 1, 3'd6, 0); idle(1);

    // R5: random traffic; identify fixed bits checked on every read
    phase = "R5";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      wrEn     = ($urandom_range(0, 5) == 0);
      wrAddr   = 3'($urandom_range(0, 2));
      wrData   = 8'($urandom);
      rdEn     = ($urandom_range(0, 2) == 0);
      rdAddr   = 3'($urandom_range(0, 5));
      cntDone  = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 3) == 0) afcIn = ~afcIn;
      if ($urandom_range(0, 4) == 0) fsIn = 7'($urandom);
      if ($urandom_range(0, 5) == 0) stereoIn = ~stereoIn;
    end
    idle(2);
    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule